// File: doc/BRIEF.md
# TFT Raster Sync Timing Generator

This block produces the raster timing for an active-matrix LCD panel. It divides the system clock down to a pixel rate. From that rate it derives four panel strobes: a line sync, a frame sync, a data-valid (output enable) and a shift clock. It also reports the pixel position being scanned and raises a one-cycle data request at the start of every visible pixel. A pixel fetch engine, which is not part of this block, uses that request to present the next pixel.

Every timing quantity comes in as a configuration field. Horizontal intervals are counted in pixel periods, and each horizontal field has a fixed offset added to it. Vertical intervals are counted in whole lines. Timing fields are captured only when a new frame begins, so a frame in progress never mixes old and new settings. The polarity bits and the shift-clock gating choice act immediately.

The block counts a line as four back-to-back phases: the visible pixels, a front wait, the sync pulse and a back wait. It counts a frame the same way, using lines: visible lines, a front wait, the sync and a back wait.

Top module: `tft_raster_timer`

## Requirements
- R1: The shift clock repeats every `divSel`+1 system clocks, and `divSel` must be at least 1. Within each pixel, the raw (non-inverted) clock is high for the last `divSel` − floor(`divSel`/2) system clocks.
- R2: On each visible line the data-valid strobe stays active for `activeW`×(`divSel`+1) system clocks. During that window `dataReq` pulses exactly `activeW` times, and `pixX` reads 0, 1, 2 … at successive pulses.
- R3: From the end of data-valid to the start of line sync there are (`hFront`+1) pixel periods.
- R4: Line sync stays active for (`hSyncLen`+1) pixel periods.
- R5: From the end of line sync to the next data-valid there are (`hBack`+3) pixel periods.
- R6: A full line lasts `activeW` + `hFront` + `hSyncLen` + `hBack` + 5 pixel periods, and the data-valid strobe and line sync are never active together.
- R7: Frame sync stays active for `vSyncLen` whole lines, so it covers exactly `vSyncLen` line-sync pulses. A frame lasts `activeH` + `vFront` + `vSyncLen` + `vBack` lines.
- R8: Each strobe has its own invert bit (`invSclk`, `invLine`, `invFrame`, `invValid`). When the bit is 0 the strobe is active-high and idles at 0. When the bit is 1 the strobe is active-low and idles at 1.
- R9: With `sclkGate`=1, the shift clock is held at its inactive level whenever data-valid is inactive. With `sclkGate`=0 it keeps running through blanking.
- R10: A change to a timing field in mid-frame does not alter the current frame. It takes effect from the first line of the next frame.
- R11: When `enable` is deasserted, all four strobes take their inactive levels from the second clock edge onward, and `dataReq`, `pixX` and `pixY` read 0. When `enable` is reasserted, scanning restarts at pixel (0,0): the first `dataReq` appears at the second clock edge with `pixX`=`pixY`=0.
- R12: Coming out of reset with `enable` low and all invert bits 0, every strobe, `dataReq`, `pixX` and `pixY` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the raster generator |
| divSel | input | DIV_W | Pixel divider; pixel period is divSel+1 clocks |
| hFront | input | FLD_W | Data-valid end to line sync, minus 1 |
| hSyncLen | input | FLD_W | Line sync width, minus 1 |
| hBack | input | FLD_W | Line sync end to data-valid, minus 3 |
| vFront | input | FLD_W | Lines from last visible line to frame sync |
| vSyncLen | input | FLD_W | Frame sync width in lines |
| vBack | input | FLD_W | Lines from frame sync end to first visible line |
| activeW | input | XY_W | Visible pixels per line |
| activeH | input | XY_W | Visible lines per frame |
| invSclk | input | 1 | Invert shift clock |
| invLine | input | 1 | Invert line sync |
| invFrame | input | 1 | Invert frame sync |
| invValid | input | 1 | Invert data-valid |
| sclkGate | input | 1 | 1: stop shift clock outside visible data |
| lcdSclk | output | 1 | Panel shift clock |
| lcdLine | output | 1 | Panel line sync |
| lcdFrame | output | 1 | Panel frame sync |
| lcdValid | output | 1 | Panel data-valid (output enable) |
| pixX | output | XY_W | Current pixel column |
| pixY | output | XY_W | Current line |
| dataReq | output | 1 | One-clock request at the start of each visible pixel |

## Verification
Every output passes through exactly one register after the counters. A strobe therefore shows the counter state of the previous clock, and `enable` changes reach the pins at the second edge. The bench drives inputs and samples outputs on falling edges. Horizontal and vertical quantities are measured as counts of samples between edges of the strobes themselves, so the one-cycle latency cancels out and each interval is compared in whole system clocks against the field arithmetic. The enable and disable checks sample at the second falling edge after the change. The frame-boundary check starts measuring right after the first visible line of a frame has begun, then looks again at the next frame.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Strobes handed from the sequencing logic to the output stage
  typedef struct packed {
    logic run;     // generator is scanning
    logic active;  // visible pixel
    logic hsync;   // inside line sync phase
    logic vsync;   // inside frame sync lines
    logic sclk;    // raw shift clock phase
    logic req;     // first system clock of a visible pixel
  } rasterStrb_t;

  localparam int STRB_N = 4;  // strobes that carry a polarity bit

endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int FLD_W = 8,
  parameter int XY_W  = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divSel,
  input  logic [FLD_W-1:0] hFront,
  input  logic [FLD_W-1:0] hSyncLen,
  input  logic [FLD_W-1:0] hBack,
  input  logic [FLD_W-1:0] vFront,
  input  logic [FLD_W-1:0] vSyncLen,
  input  logic [FLD_W-1:0] vBack,
  input  logic [XY_W-1:0]  activeW,
  input  logic [XY_W-1:0]  activeH,
  output rasterStrb_t      strb,
  output logic [XY_W-1:0]  curX,
  output logic [XY_W-1:0]  curY
);

  localparam int BASE_W = (XY_W > FLD_W) ? XY_W : FLD_W;
  localparam int CNT_W  = BASE_W + 2;

  // Shadow copies of the timing fields, captured at frame start
  logic [DIV_W-1:0] shDiv;
  logic [FLD_W-1:0] shHFront, shHSync, shHBack, shVFront, shVSync, shVBack;
  logic [XY_W-1:0]  shW, shH;

  logic             running;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] xCnt, yCnt;

  logic [CNT_W-1:0] hSyncBeg, hSyncEnd, lineLen;
  logic [CNT_W-1:0] vSyncBeg, vSyncEnd, frameLen;
  logic             tick, xLast, yLast, frameWrap, loadCfg;

  always_comb begin
    hSyncBeg = CNT_W'(shW) + CNT_W'(shHFront) + CNT_W'(1);
    hSyncEnd = hSyncBeg + CNT_W'(shHSync) + CNT_W'(1);
    lineLen  = hSyncEnd + CNT_W'(shHBack) + CNT_W'(3);
    vSyncBeg = CNT_W'(shH) + CNT_W'(shVFront);
    vSyncEnd = vSyncBeg + CNT_W'(shVSync);
    frameLen = vSyncEnd + CNT_W'(shVBack);
  end

  assign tick      = (divCnt == shDiv);
  assign xLast     = (xCnt == lineLen - CNT_W'(1));
  assign yLast     = (yCnt == frameLen - CNT_W'(1));
  assign frameWrap = running && tick && xLast && yLast;
  assign loadCfg   = enable && (!running || frameWrap);

  // Timing field capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shDiv    <= '0;
      shHFront <= '0;
      shHSync  <= '0;
      shHBack  <= '0;
      shVFront <= '0;
      shVSync  <= '0;
      shVBack  <= '0;
      shW      <= '0;
      shH      <= '0;
    end else if (loadCfg) begin
      shDiv    <= divSel;
      shHFront <= hFront;
      shHSync  <= hSyncLen;
      shHBack  <= hBack;
      shVFront <= vFront;
      shVSync  <= vSyncLen;
      shVBack  <= vBack;
      shW      <= activeW;
      shH      <= activeH;
    end
  end

  // Pixel divider and raster counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      xCnt    <= '0;
      yCnt    <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      divCnt  <= '0;
      xCnt    <= '0;
      yCnt    <= '0;
    end else if (!running) begin
      running <= 1'b1;
      divCnt  <= '0;
      xCnt    <= '0;
      yCnt    <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (tick) begin
        if (xLast) begin
          xCnt <= '0;
          yCnt <= yLast ? '0 : yCnt + CNT_W'(1);
        end else begin
          xCnt <= xCnt + CNT_W'(1);
        end
      end
    end
  end

  logic visible;
  assign visible = running && (xCnt < CNT_W'(shW)) && (yCnt < CNT_W'(shH));

  always_comb begin
    strb.run    = running;
    strb.active = visible;
    strb.hsync  = running && (xCnt >= hSyncBeg) && (xCnt < hSyncEnd);
    strb.vsync  = running && (yCnt >= vSyncBeg) && (yCnt < vSyncEnd);
    strb.sclk   = running && (divCnt > (shDiv >> 1));
    strb.req    = visible && (divCnt == '0);
  end

  assign curX = xCnt[XY_W-1:0];
  assign curY = yCnt[XY_W-1:0];

  // R1: divider never runs past the captured divide value
  assert_div_bound_R1 : assert property (@(posedge clk) disable iff (!rstN)
    running |-> divCnt <= shDiv);

  // R6: pixel counter stays inside the line, data-valid and line sync disjoint
  assert_line_bound_R6 : assert property (@(posedge clk) disable iff (!rstN)
    running |-> xCnt < lineLen);
  assert_sync_apart_R6 : assert property (@(posedge clk) disable iff (!rstN)
    running |-> !(strb.hsync && strb.active));

  // R7: line counter stays inside the frame
  assert_frame_bound_R7 : assert property (@(posedge clk) disable iff (!rstN)
    running |-> yCnt < frameLen);

  // R10: captured fields hold steady through a running frame
  assert_cfg_hold_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (running && enable && !frameWrap) |=>
      ($stable(shW) && $stable(shH) && $stable(shDiv) && $stable(shHSync)
       && $stable(shVSync)));

endmodule

// File: rtl/raster_out.sv
module raster_out
  import raster_pkg::*;
#(
  parameter int XY_W = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  rasterStrb_t     strb,
  input  logic [XY_W-1:0] curX,
  input  logic [XY_W-1:0] curY,
  input  logic            invSclk,
  input  logic            invLine,
  input  logic            invFrame,
  input  logic            invValid,
  input  logic            sclkGate,
  output logic            lcdSclk,
  output logic            lcdLine,
  output logic            lcdFrame,
  output logic            lcdValid,
  output logic [XY_W-1:0] pixX,
  output logic [XY_W-1:0] pixY,
  output logic            dataReq
);

  logic              sclkOn;
  logic [STRB_N-1:0] rawVec, invVec, outVec;

  assign sclkOn = strb.sclk && (!sclkGate || strb.active);
  assign rawVec = {sclkOn, strb.vsync, strb.hsync, strb.active};
  assign invVec = {invSclk, invFrame, invLine, invValid};

  // One polarity register per strobe
  for (genvar i = 0; i < STRB_N; i++) begin : g_pol
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outVec[i] <= 1'b0;
      else       outVec[i] <= rawVec[i] ^ invVec[i];
    end
  end

  assign {lcdSclk, lcdFrame, lcdLine, lcdValid} = outVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixX    <= '0;
      pixY    <= '0;
      dataReq <= 1'b0;
    end else begin
      pixX    <= strb.run ? curX : '0;
      pixY    <= strb.run ? curY : '0;
      dataReq <= strb.req;
    end
  end

  // R11: a stopped generator leaves the pins idle
  assert_idle_pins_R11 : assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (lcdValid == $past(invValid) && lcdLine == $past(invLine)
                   && lcdFrame == $past(invFrame) && !dataReq));

  // R9: gated shift clock stays quiet in blanking
  assert_gate_quiet_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && sclkGate && !strb.active) |=> lcdSclk == $past(invSclk));

  // R2: a data request only appears while data-valid is active
  assert_req_visible_R2 : assert property (@(posedge clk) disable iff (!rstN)
    dataReq |-> lcdValid != $past(invValid));

endmodule

// File: rtl/tft_raster_timer.sv
module tft_raster_timer
  import raster_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int FLD_W = 8,
  parameter int XY_W  = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divSel,
  input  logic [FLD_W-1:0] hFront,
  input  logic [FLD_W-1:0] hSyncLen,
  input  logic [FLD_W-1:0] hBack,
  input  logic [FLD_W-1:0] vFront,
  input  logic [FLD_W-1:0] vSyncLen,
  input  logic [FLD_W-1:0] vBack,
  input  logic [XY_W-1:0]  activeW,
  input  logic [XY_W-1:0]  activeH,
  input  logic             invSclk,
  input  logic             invLine,
  input  logic             invFrame,
  input  logic             invValid,
  input  logic             sclkGate,
  output logic             lcdSclk,
  output logic             lcdLine,
  output logic             lcdFrame,
  output logic             lcdValid,
  output logic [XY_W-1:0]  pixX,
  output logic [XY_W-1:0]  pixY,
  output logic             dataReq
);

  rasterStrb_t     strb;
  logic [XY_W-1:0] curX, curY;

  raster_ctrl #(.DIV_W(DIV_W), .FLD_W(FLD_W), .XY_W(XY_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .divSel(divSel),
    .hFront(hFront), .hSyncLen(hSyncLen), .hBack(hBack),
    .vFront(vFront), .vSyncLen(vSyncLen), .vBack(vBack),
    .activeW(activeW), .activeH(activeH),
    .strb(strb), .curX(curX), .curY(curY)
  );

  raster_out #(.XY_W(XY_W)) i_out (
    .clk(clk), .rstN(rstN), .strb(strb), .curX(curX), .curY(curY),
    .invSclk(invSclk), .invLine(invLine), .invFrame(invFrame),
    .invValid(invValid), .sclkGate(sclkGate),
    .lcdSclk(lcdSclk), .lcdLine(lcdLine), .lcdFrame(lcdFrame),
    .lcdValid(lcdValid), .pixX(pixX), .pixY(pixY), .dataReq(dataReq)
  );

endmodule

// File: tb/test_tft_raster_timer.sv
`timescale 1ns/1ps
module test_tft_raster_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  divSel = 8'd1, hFront = '0, hSyncLen = '0, hBack = '0;
  logic [7:0]  vFront = '0, vSyncLen = '0, vBack = '0;
  logic [10:0] activeW = 11'd8, activeH = 11'd4;
  logic        invSclk = 0, invLine = 0, invFrame = 0, invValid = 0, sclkGate = 0;
  logic        lcdSclk, lcdLine, lcdFrame, lcdValid, dataReq;
  logic [10:0] pixX, pixY;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  tft_raster_timer i_tft_raster_timer (
    .clk(clk), .rstN(rstN), .enable(enable), .divSel(divSel),
    .hFront(hFront), .hSyncLen(hSyncLen), .hBack(hBack),
    .vFront(vFront), .vSyncLen(vSyncLen), .vBack(vBack),
    .activeW(activeW), .activeH(activeH),
    .invSclk(invSclk), .invLine(invLine), .invFrame(invFrame),
    .invValid(invValid), .sclkGate(sclkGate),
    .lcdSclk(lcdSclk), .lcdLine(lcdLine), .lcdFrame(lcdFrame),
    .lcdValid(lcdValid), .pixX(pixX), .pixY(pixY), .dataReq(dataReq)
  );

  // div hF hS hB vF vS vB w h | valid gap1 sync gap2 line frameLines
  localparam int NV = 3;
  localparam int VEC [NV][15] = '{
    '{1, 2, 1, 0, 1, 2, 1, 8, 4, 16, 6,  4,  6, 32,  8},
    '{2, 0, 3, 4, 1, 2, 1, 5, 4, 15, 3, 12, 21, 51,  8},
    '{3, 1, 0, 2, 2, 1, 3, 3, 4, 12, 8,  4, 20, 44, 10}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sig(input int s);
    case (s)
      0: return lcdValid;
      1: return lcdLine;
      2: return lcdFrame;
      default: return lcdSclk;
    endcase
  endfunction

  task automatic waitVal(input int s, input logic v);
    while (sig(s) !== v) @(negedge clk);
  endtask

  task automatic countWhile(input int s, input logic v, output int n);
    n = 0;
    while (sig(s) === v) begin n++; @(negedge clk); end
  endtask

  task automatic loadVec(input int k);
    divSel = 8'(VEC[k][0]); hFront = 8'(VEC[k][1]); hSyncLen = 8'(VEC[k][2]);
    hBack = 8'(VEC[k][3]); vFront = 8'(VEC[k][4]); vSyncLen = 8'(VEC[k][5]);
    vBack = 8'(VEC[k][6]); activeW = 11'(VEC[k][7]); activeH = 11'(VEC[k][8]);
  endtask

  task automatic restart();
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
  endtask

  // Measure first visible line of the next frame (active-high data-valid and line sync)
  task automatic measureLine(output int vN, output int g1, output int sN,
                             output int g2, output int sAct, output int sBlank,
                             output int reqN, output int pixErr);
    vN = 0; g1 = 0; sN = 0; g2 = 0; sAct = 0; sBlank = 0; reqN = 0; pixErr = 0;
    waitVal(2, 1'b1); waitVal(2, 1'b0); waitVal(0, 1'b1);
    while (lcdValid === 1'b1) begin
      if (dataReq === 1'b1) begin
        if (pixX !== 11'(reqN) || pixY !== 11'd0) pixErr++;
        reqN++;
      end
      sAct += int'(lcdSclk);
      vN++; @(negedge clk);
    end
    while (lcdLine === 1'b0) begin g1++; sBlank += int'(lcdSclk); @(negedge clk); end
    while (lcdLine === 1'b1) begin sN++; sBlank += int'(lcdSclk); @(negedge clk); end
    while (lcdValid === 1'b0) begin g2++; sBlank += int'(lcdSclk); @(negedge clk); end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    int vN, g1, sN, g2, sAct, sBlank, reqN, pixErr, hi, lo, hsCnt, n;
    logic prevLine;

    // R12: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 idle strobes", int'({lcdSclk, lcdLine, lcdFrame, lcdValid, dataReq}), 0);
    check("R12 position", int'(pixX) + int'(pixY), 0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      loadVec(k);
      restart();
      measureLine(vN, g1, sN, g2, sAct, sBlank, reqN, pixErr);
      check($sformatf("R2 valid width v%0d", k), vN, VEC[k][9]);
      check($sformatf("R2 request count v%0d", k), reqN, VEC[k][7]);
      check($sformatf("R2 pixX sequence v%0d", k), pixErr, 0);
      check($sformatf("R3 front gap v%0d", k), g1, VEC[k][10]);
      check($sformatf("R4 sync width v%0d", k), sN, VEC[k][11]);
      check($sformatf("R5 back gap v%0d", k), g2, VEC[k][12]);
      check($sformatf("R6 line length v%0d", k), vN + g1 + sN + g2, VEC[k][13]);
      check($sformatf("R9 free-running blank sclk v%0d", k), sBlank,
            (VEC[k][1] + VEC[k][2] + VEC[k][3] + 5) * (VEC[k][0] - VEC[k][0] / 2));
      // R1: shift clock period and high time
      waitVal(3, 1'b0); waitVal(3, 1'b1);
      countWhile(3, 1'b1, hi); countWhile(3, 1'b0, lo);
      check($sformatf("R1 sclk high v%0d", k), hi, VEC[k][0] - VEC[k][0] / 2);
      check($sformatf("R1 sclk period v%0d", k), hi + lo, VEC[k][0] + 1);
      // R7: frame sync covers vSyncLen line pulses; frame length in lines
      waitVal(2, 1'b0); waitVal(2, 1'b1);
      hsCnt = 0; hi = 0; prevLine = lcdLine;
      while (lcdFrame === 1'b1) begin
        if (lcdLine === 1'b1 && prevLine === 1'b0) hsCnt++;
        prevLine = lcdLine; hi++; @(negedge clk);
      end
      countWhile(2, 1'b0, lo);
      check($sformatf("R7 frame sync lines v%0d", k), hsCnt, VEC[k][5]);
      check($sformatf("R7 frame length v%0d", k), hi + lo, VEC[k][13] * VEC[k][14]);
    end

    // R9: gated shift clock
    loadVec(0);
    sclkGate = 1'b1;
    restart();
    measureLine(vN, g1, sN, g2, sAct, sBlank, reqN, pixErr);
    check("R9 gated blank sclk", sBlank, 0);
    check("R9 gated active sclk", sAct, 8);
    sclkGate = 1'b0;

    // R8: inverted polarity
    invSclk = 1; invLine = 1; invFrame = 1; invValid = 1;
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 inverted idle levels", int'({lcdSclk, lcdLine, lcdFrame, lcdValid}), 15);
    enable = 1'b1;
    waitVal(1, 1'b0); waitVal(1, 1'b1); waitVal(1, 1'b0);
    countWhile(1, 1'b0, n);
    check("R8 active-low line sync width", n, 4);
    waitVal(0, 1'b1); waitVal(0, 1'b0);
    countWhile(0, 1'b0, n);
    check("R8 active-low valid width", n, 16);
    invSclk = 0; invLine = 0; invFrame = 0; invValid = 0;

    // R10: mid-frame width change held off until the next frame
    loadVec(0);
    restart();
    waitVal(2, 1'b1); waitVal(2, 1'b0); waitVal(0, 1'b1);
    activeW = 11'd6;
    countWhile(0, 1'b1, n);
    check("R10 current frame keeps old width", n, 16);
    waitVal(0, 1'b1);
    countWhile(0, 1'b1, n);
    check("R10 later line keeps old width", n, 16);
    measureLine(vN, g1, sN, g2, sAct, sBlank, reqN, pixErr);
    check("R10 next frame uses new width", vN, 12);

    // R11: disable and restart
    @(negedge clk); enable = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R11 disabled strobes", int'({lcdSclk, lcdLine, lcdFrame, lcdValid, dataReq}), 0);
    check("R11 disabled position", int'(pixX) + int'(pixY), 0);
    repeat (5) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check("R11 no request after one edge", int'(dataReq), 0);
    @(negedge clk);
    check("R11 first request at second edge", int'(dataReq), 1);
    check("R11 restart at origin", int'(pixX) + int'(pixY), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule